// File: doc/BRIEF.md
# Dual-Mode PWM Timebase Counter

This block is the time reference for one PWM generator. A 16-bit counter steps once per enabled clock and runs either as a repeating down-counter (period value down to zero, then back to the period value) or as a triangle counter (zero up to the period value and back down to zero). The count, a direction flag and two single-cycle event pulses (count reached zero, count reached the period value) are all registered outputs. Downstream comparators and output-action logic use these outputs to place PWM edges. Down-counting suits edge-aligned waveforms. Triangle counting suits centre-aligned waveforms.

The period value on `load_val` may change at any time. The counter adopts a new value only when it passes through zero, so a period already under way always completes with the value it started with. Pulling `en` low freezes the counter.

Top module: `pwmtb_timebase`

## Requirements
- R1: While `rst` is high at a rising clock edge: if `mode_sel`=0 (down mode), `count` becomes `load_val` and `dir` becomes 0; if `mode_sel`=1 (triangle mode), `count` becomes 0 and `dir` becomes 1. In both modes `zero_evt` and `top_evt` become 0.
- R2: In down mode each enabled edge lowers `count` by one. From 0 it reloads the active period value.
- R3: In triangle mode each enabled edge steps `count` through 0,1,...,P,P-1,...,1,0,1,... where P is the active period value.
- R4: In down mode `dir` is 0 after every edge. In triangle mode `dir` is 1 while `count` is in 0..P-1 on the rising leg and 0 while `count` is in P..1 on the falling leg.
- R5: `zero_evt` is 1 for the cycle after an enabled edge that makes `count` equal 0. Otherwise it is 0.
- R6: `top_evt` is 1 for the cycle after an enabled edge that makes `count` equal the active period value. Otherwise it is 0.
- R7: The active period value takes `load_val` only at reset and at an enabled edge where `count` is 0. A change made mid-period does not shorten or lengthen that period.
- R8: When `en` is 0, `count` holds and both event outputs are 0. `dir` holds in triangle mode and is 0 in down mode.
- R9: A period value of 0 keeps `count` at 0, and both `zero_evt` and `top_evt` are 1 after every enabled edge.
- R10: The count is 16 bits wide. A period of 16'hFFFF runs the full range without wrapping early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Step enable. When low, the counter holds |
| mode_sel | input | 1 | 0 = repeating down count, 1 = triangle count |
| load_val | input | 16 | Requested period value |
| count | output | 16 | Current counter value |
| dir | output | 1 | 1 = counting up, 0 = counting down or down mode |
| zero_evt | output | 1 | Single-cycle pulse: count reached 0 |
| top_evt | output | 1 | Single-cycle pulse: count reached the period value |

## Verification
Two events fall in the same cycle when the counter wraps at zero: the period reload and the zero handling both happen there. A different `load_val` is therefore written mid-period in both modes, and the bench checks that the old period finishes and the new one starts only at the wrap. With a period value of 0 the zero and top events coincide on every enabled edge. The bench drives that case in both modes and expects both pulses high together. A scoreboard model predicts count, direction and both pulses for every cycle and compares them one edge later.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
  typedef enum logic {
    MODE_DOWN = 1'b0,
    MODE_TRI  = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/pwmtb_period_reg.sv
module pwmtb_period_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] period
);
  // Active period: captured at reset and at every wrap through zero only.
  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      period <= load_val;
    end
  end
endmodule

// File: rtl/pwmtb_next_state.sv
module pwmtb_next_state
  import pwmtb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir,
  input  logic [CNT_W-1:0] eff_period,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic             nxt_dir
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic at_zero;
  assign at_zero = (cnt == ZERO);

  always_comb begin
    nxt_cnt = cnt;
    nxt_dir = 1'b0;
    if (mode == MODE_DOWN) begin
      nxt_cnt = at_zero ? eff_period : cnt - ONE;
      nxt_dir = 1'b0;
    end else begin
      if (at_zero) begin
        if (eff_period == ZERO) begin
          nxt_cnt = ZERO;
          nxt_dir = 1'b1;
        end else begin
          nxt_cnt = ONE;
          nxt_dir = (eff_period != ONE);
        end
      end else if (dir && (cnt < eff_period)) begin
        nxt_cnt = cnt + ONE;
        nxt_dir = ((cnt + ONE) != eff_period);
      end else begin
        nxt_cnt = cnt - ONE;
        nxt_dir = (cnt == ONE);
      end
    end
  end
endmodule

// File: rtl/pwmtb_event_reg.sv
module pwmtb_event_reg
  import pwmtb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] nxt_cnt,
  input  logic             nxt_dir,
  input  logic [CNT_W-1:0] eff_period,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dir_q,
  output logic             zero_q,
  output logic             top_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= (mode == MODE_TRI) ? '0 : load_val;
      dir_q  <= (mode == MODE_TRI);
      zero_q <= 1'b0;
      top_q  <= 1'b0;
    end else if (en) begin
      cnt_q  <= nxt_cnt;
      dir_q  <= nxt_dir;
      zero_q <= (nxt_cnt == '0);
      top_q  <= (nxt_cnt == eff_period);
    end else begin
      zero_q <= 1'b0;
      top_q  <= 1'b0;
      if (mode == MODE_DOWN) begin
        dir_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwmtb_timebase.sv
module pwmtb_timebase
  import pwmtb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mode_sel,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             dir,
  output logic             zero_evt,
  output logic             top_evt
);
  cnt_mode_e        mode;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] eff_period;
  logic [CNT_W-1:0] nxt_cnt;
  logic             nxt_dir;
  logic             wrap;

  assign mode       = cnt_mode_e'(mode_sel);
  assign wrap       = en && (count == '0);
  assign eff_period = wrap ? load_val : period;

  pwmtb_period_reg #(.CNT_W(CNT_W)) u_period (
    .clk      (clk),
    .rst      (rst),
    .wrap     (wrap),
    .load_val (load_val),
    .period   (period)
  );

  pwmtb_next_state #(.CNT_W(CNT_W)) u_next (
    .mode       (mode),
    .cnt        (count),
    .dir        (dir),
    .eff_period (eff_period),
    .nxt_cnt    (nxt_cnt),
    .nxt_dir    (nxt_dir)
  );

  pwmtb_event_reg #(.CNT_W(CNT_W)) u_evt (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .mode       (mode),
    .load_val   (load_val),
    .nxt_cnt    (nxt_cnt),
    .nxt_dir    (nxt_dir),
    .eff_period (eff_period),
    .cnt_q      (count),
    .dir_q      (dir),
    .zero_q     (zero_evt),
    .top_q      (top_evt)
  );
endmodule

// File: rtl/pwmtb_timebase_chk.sv
module pwmtb_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             mode_sel,
  input logic [CNT_W-1:0] count,
  input logic             dir,
  input logic             zero_evt,
  input logic             top_evt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !zero_evt && !top_evt);

  a_r2_down_step: assert property (@(posedge clk) disable iff (rst)
    (en && !mode_sel && count != '0) |=> count == $past(count) - ONE);

  a_r3_tri_step: assert property (@(posedge clk) disable iff (rst)
    (en && mode_sel) |=> (count == $past(count) + ONE) ||
                         (count == $past(count) - ONE) || (count == '0));

  a_r4_dir_low_down: assert property (@(posedge clk) disable iff (rst)
    !mode_sel |=> !dir);

  a_r5_zero_match: assert property (@(posedge clk) disable iff (rst)
    zero_evt |-> count == '0);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count) && !zero_evt && !top_evt);
endmodule

bind pwmtb_timebase pwmtb_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .mode_sel (mode_sel),
  .count    (count),
  .dir      (dir),
  .zero_evt (zero_evt),
  .top_evt  (top_evt)
);

// File: tb/sim_pwmtb_timebase.sv
module sim_pwmtb_timebase;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         mode_sel = 1'b0;
  logic [W-1:0] load_val = 16'd5;
  logic [W-1:0] count;
  logic         dir, zero_evt, top_evt;

  always #5 clk = ~clk;

  pwmtb_timebase #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .en(en), .mode_sel(mode_sel), .load_val(load_val),
    .count(count), .dir(dir), .zero_evt(zero_evt), .top_evt(top_evt)
  );

  typedef struct {
    logic [W-1:0] cnt;
    logic         d;
    logic         z;
    logic         t;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  logic [W-1:0] m_cnt = '0;
  logic         m_dir = 1'b0;
  logic [W-1:0] m_per = '0;
  logic         m_z = 1'b0;
  logic         m_t = 1'b0;

  task automatic model_edge(input logic r, input logic e, input logic m, input logic [W-1:0] lv);
    logic [W-1:0] p;
    if (r) begin
      m_per = lv;
      m_cnt = m ? '0 : lv;
      m_dir = m;
      m_z = 0; m_t = 0;
    end else if (!e) begin
      m_z = 0; m_t = 0;
      if (!m) m_dir = 0;
    end else begin
      p = m_per;
      if (m_cnt == 0) begin p = lv; m_per = lv; end
      if (!m) begin
        m_cnt = (m_cnt == 0) ? p : m_cnt - 1;
        m_dir = 0;
      end else if (m_dir && m_cnt < p) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == p) m_dir = 0;
      end else if (m_cnt == 0) begin
        m_dir = 1;   // period 0: stay at zero
      end else begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_dir = 1;
      end
      m_z = (m_cnt == 0);
      m_t = (m_cnt == p);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic m,
                      input logic [W-1:0] lv, input string tag);
    exp_t it;
    @(negedge clk);
    rst = r; en = e; mode_sel = m; load_val = lv;
    model_edge(r, e, m, lv);
    it.cnt = m_cnt; it.d = m_dir; it.z = m_z; it.t = m_t; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run(input int n, input logic r, input logic e, input logic m,
                     input logic [W-1:0] lv, input string tag);
    for (int i = 0; i < n; i++) step(r, e, m, lv, tag);
  endtask

  // Monitor: compare one edge after each driven cycle
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (count !== it.cnt || dir !== it.d || zero_evt !== it.z || top_evt !== it.t) begin
        errors++;
        $display("FAIL %s: count=%h dir=%b zero=%b top=%b expected count=%h dir=%b zero=%b top=%b",
                 it.tag, count, dir, zero_evt, top_evt, it.cnt, it.d, it.z, it.t);
      end
    end
  end

  initial begin
    // R1: reset in down mode loads the period value
    run(2, 1, 0, 0, 16'd5, "R1");
    // R2/R5/R6: down counting with zero and top pulses
    run(14, 0, 1, 0, 16'd5, "R2/R5/R6");
    // R7: mid-period change, old period must finish
    run(3, 0, 1, 0, 16'd3, "R7");
    run(10, 0, 1, 0, 16'd3, "R7");
    // R8: hold while disabled
    run(4, 0, 0, 0, 16'd9, "R8");
    run(3, 0, 1, 0, 16'd3, "R8");
    // R1: reset in triangle mode
    run(2, 1, 0, 1, 16'd4, "R1");
    // R3/R4/R5/R6: triangle counting
    run(20, 0, 1, 1, 16'd4, "R3/R4/R5/R6");
    // R7: triangle period change mid-leg
    run(3, 0, 1, 1, 16'd2, "R7");
    run(12, 0, 1, 1, 16'd2, "R7");
    // R8: triangle hold keeps dir
    run(2, 0, 1, 1, 16'd2, "R8");
    run(3, 0, 0, 1, 16'd2, "R8");
    run(4, 0, 1, 1, 16'd2, "R8");
    // R4: switch to down mode, dir must go low
    run(6, 0, 1, 0, 16'd2, "R4");
    // R9: period zero in down mode, then triangle mode
    run(8, 0, 1, 0, 16'd0, "R9");
    run(1, 1, 0, 1, 16'd0, "R9");
    run(6, 0, 1, 1, 16'd0, "R9");
    // R10: full 16-bit range in down mode
    run(1, 1, 0, 0, 16'hFFFF, "R10");
    run(65538, 0, 1, 0, 16'hFFFF, "R10");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule